// File: doc/BRIEF.md
# Program Memory Region Router with Wait-State Control

This block sits between a CPU's instruction fetch port and three program stores. Each fetch address goes to exactly one of them: a fast on-chip read-only region at the bottom of the 64 KiB space, a fast on-chip writable region at the top, or an off-chip device that covers the addresses in between. A force-off-chip input sends every fetch to the off-chip device, whatever the address.

Fetches that hit either on-chip region never stall the CPU. Fetches that go off-chip raise a stall output for a programmable number of wait cycles, held in a 3-bit register. If the off-chip device's ready input is low when the count runs out, the stall stays up one cycle at a time until ready returns. The CPU keeps its request and address steady while stall is high. The read byte is registered on the clock edge that ends the completing cycle and appears with a one-cycle valid pulse. The block also routes program-write strobes into the on-chip writable region, so a loader can place code there.

Top module: `pmem_router`

## Requirements
- R1: A fetch address below ROM_TOP (default 0x0400) selects the on-chip read-only region (rom_en). An address at or above RAM_BASE (default 0xF000) selects the on-chip writable region (ram_en). Any other address selects off-chip memory (ext_en). At most one of the three is active for a fetch.
- R2: While force_ext is high, every fetch selects off-chip memory (ext_en high, rom_en and ram_en low) and takes the off-chip wait timing.
- R3: An on-chip fetch never raises stall. fetch_valid is high in the following cycle, with fetch_data equal to the selected region's read byte.
- R4: An off-chip fetch with a wait count of N (ext_ready high) keeps stall high for exactly N cycles, starting with the request cycle, and low in cycle N. fetch_valid and the off-chip byte follow one cycle later. N = 0 gives no stall.
- R5: If ext_ready is low in the cycle where the wait count is used up, the stall is extended one cycle at a time until ext_ready is high. ext_ready low during earlier wait cycles does not lengthen the access.
- R6: The wait count is 3 bits wide and resets to 3. A ws_load pulse writes ws_value into it. A pulse that arrives while an off-chip fetch is in progress is ignored.
- R7: pgm_wr with no fetch request and an address in the writable region drives ram_we and ram_en high, with ram_wdata equal to pgm_wdata. force_ext does not block such a write. A write strobe to any other address, or one that coincides with a fetch request, leaves ram_we low.
- R8: During and right after reset, stall, fetch_valid and fetch_data are all zero.
- R9: fetch_valid is a single-cycle pulse. It is high only in the cycle after a fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | CPU requests a program byte this cycle |
| fetch_addr | input | 16 | Fetch or write address from the CPU |
| force_ext | input | 1 | Route every fetch to off-chip memory |
| ws_load | input | 1 | Load the wait-count register |
| ws_value | input | 3 | New wait count |
| ext_ready | input | 1 | Off-chip device ready (low holds the access) |
| pgm_wr | input | 1 | Program write strobe |
| pgm_wdata | input | 8 | Program write byte |
| rom_rdata | input | 8 | Read byte from the on-chip read-only region |
| ram_rdata | input | 8 | Read byte from the on-chip writable region |
| ext_rdata | input | 8 | Read byte from off-chip memory |
| mem_addr | output | 16 | Address presented to all program stores |
| rom_en | output | 1 | Read-only region selected |
| ram_en | output | 1 | Writable region selected (fetch or write) |
| ram_we | output | 1 | Write enable for the writable region |
| ram_wdata | output | 8 | Write byte for the writable region |
| ext_en | output | 1 | Off-chip access in progress |
| stall | output | 1 | Hold the CPU fetch |
| fetch_valid | output | 1 | fetch_data holds a completed fetch |
| fetch_data | output | 8 | Captured program byte |

## Verification
Some properties are checked on every cycle. No more than one store is selected at a time. force_ext always wins. An on-chip fetch never stalls. The stall stays high while the elapsed count is below the limit, and at the limit when ready is low. The elapsed counter never passes the limit. A completing cycle is followed by exactly one valid pulse. A write strobe only reaches the writable region when no fetch is pending. Other behaviour can only be shown by the bench's scenarios, because it depends on the exact stall length and the data returned. That covers the address boundaries, the reset value of the wait count, the wait counts 0, 5 and 7, ready held low at or before the expiry cycle, a wait-count load during an access, and a written byte read back by a later fetch.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  localparam int PMR_AW = 16;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_ROM  = 2'd1,
    REG_RAM  = 2'd2,
    REG_OFF  = 2'd3
  } region_e;

  // Address-to-region classification; bounds are inclusive at the bottom.
  function automatic region_e classify(input logic [PMR_AW-1:0] addr,
                                       input logic [PMR_AW-1:0] rom_top,
                                       input logic [PMR_AW-1:0] ram_base);
    if (addr < rom_top)
      return REG_ROM;
    else if (addr >= ram_base)
      return REG_RAM;
    else
      return REG_OFF;
  endfunction

  // An off-chip access may finish once the elapsed count meets the limit
  // and the device reports ready.
  function automatic logic wait_over(input logic [7:0] elapsed,
                                     input logic [7:0] limit,
                                     input logic       ready);
    return (elapsed >= limit) && ready;
  endfunction

endpackage

// File: rtl/pmr_decode.sv
module pmr_decode
  import pmr_pkg::*;
#(
  parameter logic [PMR_AW-1:0] ROM_TOP  = 16'h0400,
  parameter logic [PMR_AW-1:0] RAM_BASE = 16'hF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [PMR_AW-1:0] fetch_addr,
  input  logic              force_ext,
  input  logic              pgm_wr,
  output region_e           fetch_region,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              ext_sel,
  output logic              wr_hit
);

  region_e addr_region;

  always_comb begin
    addr_region = classify(fetch_addr, ROM_TOP, RAM_BASE);
    if (!fetch_req)
      fetch_region = REG_NONE;
    else if (force_ext)
      fetch_region = REG_OFF;
    else
      fetch_region = addr_region;
  end

  assign rom_sel = (fetch_region == REG_ROM);
  assign ram_sel = (fetch_region == REG_RAM);
  assign ext_sel = (fetch_region == REG_OFF);
  // Writes use the raw address map; forcing off-chip affects fetches only.
  assign wr_hit  = pgm_wr && !fetch_req && (addr_region == REG_RAM);

  a_r1_one_store: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel, ext_sel}));

  a_r2_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && force_ext) |-> (ext_sel && !rom_sel && !ram_sel));

endmodule

// File: rtl/pmr_wait.sv
module pmr_wait
  import pmr_pkg::*;
#(
  parameter int WS_W   = 3,
  parameter int WS_RST = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ws_load,
  input  logic [WS_W-1:0] ws_value,
  input  logic            ext_active,
  input  logic            ext_ready,
  output logic            stall,
  output logic            ext_done
);

  logic [WS_W-1:0] ws_q;
  logic [WS_W-1:0] elapsed_q;
  logic            count_hit;

  assign count_hit = (elapsed_q == ws_q);
  assign ext_done  = ext_active &&
                     wait_over(8'(elapsed_q), 8'(ws_q), ext_ready);
  assign stall     = ext_active && !ext_done;

  // Wait-count register: frozen while an off-chip access runs.
  always_ff @(posedge clk) begin
    if (!rst_n)
      ws_q <= WS_W'(WS_RST);
    else if (ws_load && !ext_active)
      ws_q <= ws_value;
  end

  // Elapsed-cycle counter: saturates at the limit, clears on completion.
  always_ff @(posedge clk) begin
    if (!rst_n)
      elapsed_q <= '0;
    else if (!ext_active || ext_done)
      elapsed_q <= '0;
    else if (!count_hit)
      elapsed_q <= elapsed_q + 1'b1;
  end

  a_r4_stall_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_active && !count_hit) |-> stall);

  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_active && count_hit && !ext_ready) |-> stall);

  a_r4_counter_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed_q <= ws_q);

  a_r6_busy_freezes_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ext_active |=> $stable(ws_q) || !$past(ext_active));

endmodule

// File: rtl/pmr_capture.sv
module pmr_capture
  import pmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  region_e       region,
  input  logic          complete,
  input  logic [DW-1:0] rom_rdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] ext_rdata,
  output logic [DW-1:0] fetch_data,
  output logic          fetch_valid
);

  logic [DW-1:0] sel_byte;

  always_comb begin
    case (region)
      REG_ROM: sel_byte = rom_rdata;
      REG_RAM: sel_byte = ram_rdata;
      REG_OFF: sel_byte = ext_rdata;
      default: sel_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_data  <= '0;
      fetch_valid <= 1'b0;
    end else begin
      fetch_valid <= complete;
      if (complete)
        fetch_data <= sel_byte;
    end
  end

  a_r9_valid_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> fetch_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> !fetch_valid);

endmodule

// File: rtl/pmem_router.sv
module pmem_router
  import pmr_pkg::*;
#(
  parameter logic [15:0] ROM_TOP  = 16'h0400,
  parameter logic [15:0] RAM_BASE = 16'hF000,
  parameter int          DW       = 8,
  parameter int          WS_W     = 3,
  parameter int          WS_RST   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_req,
  input  logic [15:0]     fetch_addr,
  input  logic            force_ext,
  input  logic            ws_load,
  input  logic [WS_W-1:0] ws_value,
  input  logic            ext_ready,
  input  logic            pgm_wr,
  input  logic [DW-1:0]   pgm_wdata,
  input  logic [DW-1:0]   rom_rdata,
  input  logic [DW-1:0]   ram_rdata,
  input  logic [DW-1:0]   ext_rdata,
  output logic [15:0]     mem_addr,
  output logic            rom_en,
  output logic            ram_en,
  output logic            ram_we,
  output logic [DW-1:0]   ram_wdata,
  output logic            ext_en,
  output logic            stall,
  output logic            fetch_valid,
  output logic [DW-1:0]   fetch_data
);

  region_e fetch_region;
  logic    rom_sel, ram_sel, ext_sel, wr_hit;
  logic    ext_done;
  logic    fetch_complete;

  pmr_decode #(.ROM_TOP(ROM_TOP), .RAM_BASE(RAM_BASE)) u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .force_ext    (force_ext),
    .pgm_wr       (pgm_wr),
    .fetch_region (fetch_region),
    .rom_sel      (rom_sel),
    .ram_sel      (ram_sel),
    .ext_sel      (ext_sel),
    .wr_hit       (wr_hit)
  );

  pmr_wait #(.WS_W(WS_W), .WS_RST(WS_RST)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .ws_load    (ws_load),
    .ws_value   (ws_value),
    .ext_active (ext_sel),
    .ext_ready  (ext_ready),
    .stall      (stall),
    .ext_done   (ext_done)
  );

  // A fetch completes in any cycle it is requested and not held.
  assign fetch_complete = (rom_sel || ram_sel) || ext_done;

  pmr_capture #(.DW(DW)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .region      (fetch_region),
    .complete    (fetch_complete),
    .rom_rdata   (rom_rdata),
    .ram_rdata   (ram_rdata),
    .ext_rdata   (ext_rdata),
    .fetch_data  (fetch_data),
    .fetch_valid (fetch_valid)
  );

  assign mem_addr  = fetch_addr;
  assign rom_en    = rom_sel;
  assign ram_en    = ram_sel || wr_hit;
  assign ram_we    = wr_hit;
  assign ram_wdata = pgm_wdata;
  assign ext_en    = ext_sel;

  a_r3_onchip_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !ext_en) |-> !stall);

  a_r7_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!fetch_req && ram_en && !rom_en && !ext_en));

  a_r8_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!fetch_valid && fetch_data == '0));

endmodule

// File: tb/tb_pmem_router.sv
module tb_pmem_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req, force_ext, ws_load, ext_ready, pgm_wr;
  logic [15:0] fetch_addr;
  logic [2:0]  ws_value;
  logic [7:0]  pgm_wdata, rom_rdata, ram_rdata, ext_rdata;
  logic [15:0] mem_addr;
  logic        rom_en, ram_en, ram_we, ext_en, stall, fetch_valid;
  logic [7:0]  ram_wdata, fetch_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pmem_router dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .force_ext(force_ext), .ws_load(ws_load), .ws_value(ws_value),
    .ext_ready(ext_ready), .pgm_wr(pgm_wr), .pgm_wdata(pgm_wdata),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .ext_rdata(ext_rdata),
    .mem_addr(mem_addr), .rom_en(rom_en), .ram_en(ram_en), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ext_en(ext_en), .stall(stall),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data)
  );

  // Memory models: read-only and off-chip bytes are computed from the address.
  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] ext_byte(input logic [15:0] a);
    return (a[7:0] + 8'h3C) ^ a[15:8];
  endfunction

  logic [7:0] ram_m [256];
  initial for (int i = 0; i < 256; i++) ram_m[i] = 8'(i) ^ 8'h33;
  always @(posedge clk) if (ram_we) ram_m[mem_addr[7:0]] <= ram_wdata;
  assign rom_rdata = rom_byte(mem_addr);
  assign ext_rdata = ext_byte(mem_addr);
  assign ram_rdata = ram_m[mem_addr[7:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One fetch; ext_ready is low for cycle indices [rlo_s, rlo_e).
  task automatic do_fetch(input logic [15:0] a, input bit fx,
                          input int rlo_s, input int rlo_e, input bit mid_load,
                          input int exp_stall, input logic [7:0] exp_d,
                          input string req);
    int i = 0;
    int stalls = 0;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a; force_ext = fx;
    forever begin
      ext_ready = !(i >= rlo_s && i < rlo_e);
      if (mid_load) begin ws_load = (i == 0); ws_value = 3'd7; end
      #1;
      if (i == 0) begin
        if (fx || (a >= 16'h0400 && a < 16'hF000))
          check(ext_en && !rom_en && !ram_en, req, "off-chip select", {rom_en, ram_en, ext_en}, 3'b001);
        else if (a < 16'h0400)
          check(rom_en && !ram_en && !ext_en, req, "rom select", {rom_en, ram_en, ext_en}, 3'b100);
        else
          check(ram_en && !rom_en && !ext_en, req, "ram select", {rom_en, ram_en, ext_en}, 3'b010);
      end
      if (!stall) break;
      stalls++;
      if (i > 60) break;
      @(negedge clk);
      i++;
    end
    @(negedge clk);
    fetch_req = 1'b0; ws_load = 1'b0; ext_ready = 1'b1; force_ext = 1'b0;
    #1;
    check(stalls == exp_stall, req, "stall cycles", stalls, exp_stall);
    check(fetch_valid === 1'b1, req, "valid after completion", fetch_valid, 1);
    check(fetch_data === exp_d, req, "fetch data", fetch_data, exp_d);
    @(negedge clk); #1;
    check(fetch_valid === 1'b0, "R9", "valid is one pulse", fetch_valid, 0);
  endtask

  task automatic set_ws(input logic [2:0] v);
    @(negedge clk); ws_load = 1'b1; ws_value = v;
    @(negedge clk); ws_load = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!stall && !fetch_valid && fetch_data == 8'h00, "R8", "outputs in reset",
          {stall, fetch_valid, fetch_data}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!stall && !fetch_valid && fetch_data == 8'h00, "R8", "outputs after reset",
          {stall, fetch_valid, fetch_data}, 0);
    // R6: reset wait count is 3
    do_fetch(16'h1234, 0, 0, 0, 0, 3, ext_byte(16'h1234), "R6");
  endtask

  task automatic t_onchip;
    do_fetch(16'h0000, 0, 0, 0, 0, 0, rom_byte(16'h0000), "R3");
    do_fetch(16'h03FF, 0, 0, 0, 0, 0, rom_byte(16'h03FF), "R1");
    do_fetch(16'hF000, 0, 0, 0, 0, 0, 8'h33, "R3");
    do_fetch(16'hFFFF, 0, 0, 0, 0, 0, 8'hCC, "R1");
  endtask

  task automatic t_offchip_waits;
    do_fetch(16'h0400, 0, 0, 0, 0, 3, ext_byte(16'h0400), "R1");
    do_fetch(16'hEFFF, 0, 0, 0, 0, 3, ext_byte(16'hEFFF), "R1");
    set_ws(3'd0);
    do_fetch(16'h2000, 0, 0, 0, 0, 0, ext_byte(16'h2000), "R4");
    set_ws(3'd5);
    do_fetch(16'h2001, 0, 0, 0, 0, 5, ext_byte(16'h2001), "R4");
    set_ws(3'd7);
    do_fetch(16'h8002, 0, 0, 0, 0, 7, ext_byte(16'h8002), "R6");
  endtask

  task automatic t_ready;
    set_ws(3'd2);
    do_fetch(16'h3000, 0, 2, 5, 0, 5, ext_byte(16'h3000), "R5");
    do_fetch(16'h3001, 0, 0, 2, 0, 2, ext_byte(16'h3001), "R5");
    do_fetch(16'h3002, 0, 1, 4, 0, 4, ext_byte(16'h3002), "R5");
  endtask

  task automatic t_load_during_access;
    set_ws(3'd2);
    do_fetch(16'h4000, 0, 0, 0, 1, 2, ext_byte(16'h4000), "R6");
    do_fetch(16'h4001, 0, 0, 0, 0, 2, ext_byte(16'h4001), "R6");
  endtask

  task automatic t_force_ext;
    do_fetch(16'h0010, 1, 0, 0, 0, 2, ext_byte(16'h0010), "R2");
    do_fetch(16'hF123, 1, 0, 0, 0, 2, ext_byte(16'hF123), "R2");
  endtask

  task automatic t_write;
    @(negedge clk);
    pgm_wr = 1'b1; fetch_addr = 16'hF010; pgm_wdata = 8'h5A; force_ext = 1'b1; #1;
    check(ram_we && ram_en && ram_wdata == 8'h5A, "R7", "write to ram region",
          {ram_we, ram_en, ram_wdata}, {2'b11, 8'h5A});
    @(negedge clk);
    fetch_addr = 16'h0010; pgm_wdata = 8'h77; force_ext = 1'b0; #1;
    check(!ram_we, "R7", "write to rom region ignored", ram_we, 0);
    @(negedge clk);
    fetch_addr = 16'hF011; fetch_req = 1'b1; #1;
    check(!ram_we, "R7", "write during fetch ignored", ram_we, 0);
    @(negedge clk);
    fetch_req = 1'b0; pgm_wr = 1'b0;
    do_fetch(16'hF010, 0, 0, 0, 0, 0, 8'h5A, "R7");
    do_fetch(16'hF011, 0, 0, 0, 0, 0, 8'h11 ^ 8'h33, "R7");
    do_fetch(16'h0010, 0, 0, 0, 0, 0, rom_byte(16'h0010), "R7");
  endtask

  initial begin
    fetch_req = 0; force_ext = 0; ws_load = 0; ws_value = 0; ext_ready = 1;
    pgm_wr = 0; pgm_wdata = 0; fetch_addr = 0;
    t_reset;
    t_onchip;
    t_offchip_waits;
    t_ready;
    t_load_during_access;
    t_force_ext;
    t_write;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule